// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Register Window

This block is a real-time clock and calendar core that occupies the eight highest byte addresses of a byte-wide memory map. A running set of packed-BCD counters advances from a one-pulse-per-second strobe. The carry passes from seconds to minutes, then to hours in 24-hour form, then to the date and the day of week together, then to the month, the year and the century. The day count per month comes from the month number. A year is a leap year when its two-digit value divides by four.

Software never sees the running counters directly. It reads and writes a second, user-facing copy of the registers. Setting the freeze bit in the control byte holds that copy so that a multi-byte read is coherent, while the running counters keep time underneath. Setting the load bit stops refreshes so that software can stage a new time. Clearing the load bit copies the staged values into the counters in a single cycle. A stop bit in the seconds byte makes the counters ignore the one-second strobe. The day byte returns a live battery-good flag and carries a test bit that software can write.

Requests arrive on a valid/ready channel. `req_ready` is always high, so a request is taken in every cycle in which `req_valid` is high. A read is answered in the next cycle with a one-cycle `rsp_valid` pulse. The response channel cannot be back-pressured: the consumer must accept the pulse in the cycle it appears. Writes produce no response.

Top module: `rtc_calendar_window`

## Requirements
- R1: After reset, the registers read as follows: century 0x20, year 0x00, month 0x01, date 0x01, day-of-week 1, hours 0x00, minutes 0x00, seconds 0x00. All control bits read 0.
- R2: The window is the eight addresses whose upper ADDR_W-3 bits are all ones. The low three address bits select the register: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A write outside the window changes nothing. A read outside the window returns 0x00.
- R3: Every field is packed BCD with the tens digit in the upper nibble. Bits outside a field are dropped on write and read 0. The field masks are: century 0x3F, seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF.
- R4: A counted second past 59 rolls to 00 and carries into minutes. Minutes past 59 roll to 00 and carry into hours. Hours past 23 roll to 00 and carry into the date.
- R5: A month ends after date 31, 30 for months 04, 06, 09 and 11, 28 for month 02, or 29 for month 02 when the year value divides by four. The month then restarts at date 01 and carries into the next month. Month 12 rolls to 01 and carries into the year.
- R6: The day-of-week advances only when the hours roll over at midnight, and it steps 1 to 7 and then back to 1.
- R7: Year 99 rolls to 00 and carries into the century. The century rolls from CEN_LAST (default 0x39) to 00.
- R8: Control bit 6 is the freeze bit. While it is 1, the user registers keep their values and the running counters keep counting. Once it is 0 (and bit 7 is 0), the user registers take the running values one cycle after the clearing write.
- R9: Control bit 7 is the load bit. While it is 1, the user registers change only through writes. A control write with bit 7 at 0 while it is 1 loads the counters from the user registers, with the century taken from that write. A one-second strobe in that same cycle is discarded.
- R10: Seconds bit 7 is the stop bit. While it is 1, one-second strobes are ignored.
- R11: Day bit 7 reads the live `batt_ok` input and cannot be written. Day bit 6 is a test bit that can be read and written.
- R12: `req_ready` is always 1. Each read produces `rsp_valid` for exactly one cycle, in the cycle after the request. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| batt_ok | input | 1 | Battery-good status |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 8 | Read data |

## Verification
Two of the block's functions can fall in the same cycle. The write that clears the load bit can coincide with a one-second strobe. The bench drives both in one cycle and expects the freshly loaded seconds value to come back exactly, with no extra count. A field write can also coincide with the refresh of the user copy while both control bits are low. Here the bench writes a field with the stop bit set and expects the running value to return on the next read, with the stop bit kept. A behavioural model in the bench, built on integer arithmetic, judges every read response cycle by cycle.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;
  localparam int NCNT = 7;
  localparam int NWIN = 8;
  localparam int CI_SEC = 0, CI_MIN = 1, CI_HR = 2, CI_DATE = 3,
                 CI_MON = 4, CI_YR = 5, CI_CEN = 6;
  localparam logic [2:0] OFS_CTL = 3'd0, OFS_SEC = 3'd1, OFS_MIN = 3'd2,
                         OFS_HR = 3'd3, OFS_DAY = 3'd4, OFS_DATE = 3'd5,
                         OFS_MON = 3'd6, OFS_YR = 3'd7;
  localparam logic [2:0] DOW_FIRST = 3'd1;
  localparam logic [2:0] DOW_LAST  = 3'd7;

  function automatic logic [2:0] ofs_of_cnt(int i);
    case (i)
      CI_SEC:  return OFS_SEC;
      CI_MIN:  return OFS_MIN;
      CI_HR:   return OFS_HR;
      CI_DATE: return OFS_DATE;
      CI_MON:  return OFS_MON;
      CI_YR:   return OFS_YR;
      default: return OFS_CTL;
    endcase
  endfunction

  function automatic logic [7:0] cnt_lo(int i);
    return (i == CI_DATE || i == CI_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] cnt_hi(int i);
    case (i)
      CI_SEC, CI_MIN: return 8'h59;
      CI_HR:          return 8'h23;
      CI_DATE:        return 8'h31;
      CI_MON:         return 8'h12;
      default:        return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(logic [2:0] ofs);
    case (ofs)
      OFS_CTL, OFS_HR, OFS_DATE: return 8'h3F;
      OFS_SEC, OFS_MIN:          return 8'h7F;
      OFS_DAY:                   return 8'h07;
      OFS_MON:                   return 8'h1F;
      default:                   return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap (
  input  logic [7:0] cur,
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  input  logic       step,
  output logic [7:0] nxt,
  output logic       wrap
);
  always_comb begin
    wrap = step && (cur == hi);
    if (!step)                nxt = cur;
    else if (cur == hi)       nxt = lo;
    else if (cur[3:0] == 4'd9) nxt = {cur[7:4] + 4'd1, 4'd0};
    else                      nxt = {cur[7:4], cur[3:0] + 4'd1};
  end
endmodule

// File: rtl/rtc_month_limit.sv
module rtc_month_limit (
  input  logic [7:0] mon,
  input  logic [7:0] yr,
  output logic [7:0] last_date
);
  logic leap;
  // divisible by four: even tens with units 0/4/8, odd tens with units 2/6
  always_comb begin
    if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_window.sv
module rtc_calendar_window
  import rtc_win_pkg::*;
#(
  parameter int         ADDR_W   = 13,
  parameter logic [7:0] CEN_LAST = 8'h39,
  parameter logic [7:0] CEN_INIT = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              batt_ok,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);
  localparam int OFS_W = 3;

  logic [7:0]      cnt_q [NCNT];
  logic [7:0]      cnt_d [NCNT];
  logic [NCNT-1:0] wrap;
  logic [2:0]      dow_q;
  logic [7:0]      usr_q [NWIN];
  logic [7:0]      run_view [NWIN];
  logic            w_q, r_q, osc_q, ft_q;
  logic [7:0]      date_last, rd_view;
  logic [OFS_W-1:0] ofs;
  logic            in_win, wr_hit, rd_req, load, go;

  assign req_ready = 1'b1;
  assign ofs    = req_addr[OFS_W-1:0];
  assign in_win = &req_addr[ADDR_W-1:OFS_W];
  assign wr_hit = req_valid && req_write && in_win;
  assign rd_req = req_valid && !req_write;
  assign load   = wr_hit && (ofs == OFS_CTL) && !req_wdata[7] && w_q;
  assign go     = tick_1hz && !osc_q;

  rtc_month_limit u_mlim (
    .mon(cnt_q[CI_MON]), .yr(cnt_q[CI_YR]), .last_date(date_last)
  );

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_chain
    logic       step;
    logic [7:0] hi;
    if (gi == 0) begin : g_first
      assign step = go;
    end else begin : g_next
      assign step = wrap[gi-1];
    end
    if (gi == CI_DATE) begin : g_hdate
      assign hi = date_last;
    end else if (gi == CI_CEN) begin : g_hcen
      assign hi = CEN_LAST;
    end else begin : g_hfix
      assign hi = cnt_hi(gi);
    end
    rtc_bcd_wrap u_dig (
      .cur(cnt_q[gi]), .lo(cnt_lo(gi)), .hi(hi), .step(step),
      .nxt(cnt_d[gi]), .wrap(wrap[gi])
    );
  end

  always_comb begin
    for (int k = 0; k < NWIN; k++) run_view[k] = '0;
    for (int i = 0; i < NCNT; i++) run_view[ofs_of_cnt(i)] = cnt_q[i];
    run_view[OFS_DAY] = {5'd0, dow_q};
  end

  // running counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) cnt_q[i] <= cnt_lo(i);
      cnt_q[CI_CEN] <= CEN_INIT;
      dow_q <= DOW_FIRST;
    end else if (load) begin
      for (int i = 0; i < NCNT; i++) cnt_q[i] <= usr_q[ofs_of_cnt(i)];
      cnt_q[CI_CEN] <= req_wdata & field_mask(OFS_CTL);
      dow_q <= usr_q[OFS_DAY][2:0];
    end else begin
      for (int i = 0; i < NCNT; i++) cnt_q[i] <= cnt_d[i];
      if (wrap[CI_HR]) dow_q <= (dow_q == DOW_LAST) ? DOW_FIRST : dow_q + 3'd1;
    end
  end

  // user-visible copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) usr_q[ofs_of_cnt(i)] <= cnt_lo(i);
      usr_q[OFS_CTL] <= CEN_INIT;
      usr_q[OFS_DAY] <= {5'd0, DOW_FIRST};
    end else begin
      for (int k = 0; k < NWIN; k++) begin
        if (wr_hit && (ofs == 3'(k))) usr_q[k] <= req_wdata & field_mask(3'(k));
        else if (!w_q && !r_q)        usr_q[k] <= run_view[k];
      end
    end
  end

  // control bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= 1'b0; r_q <= 1'b0; osc_q <= 1'b0; ft_q <= 1'b0;
    end else if (wr_hit) begin
      if (ofs == OFS_CTL) begin w_q <= req_wdata[7]; r_q <= req_wdata[6]; end
      if (ofs == OFS_SEC) osc_q <= req_wdata[7];
      if (ofs == OFS_DAY) ft_q  <= req_wdata[6];
    end
  end

  always_comb begin
    case (ofs)
      OFS_CTL: rd_view = {w_q, r_q, usr_q[OFS_CTL][5:0]};
      OFS_SEC: rd_view = {osc_q, usr_q[OFS_SEC][6:0]};
      OFS_DAY: rd_view = {batt_ok, ft_q, 3'd0, usr_q[OFS_DAY][2:0]};
      default: rd_view = usr_q[ofs];
    endcase
    if (!in_win) rd_view = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rd_view;
    end
  end
endmodule

// File: rtl/rtc_window_checker.sv
module rtc_window_checker #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              batt_ok,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              osc_q,
  input logic              w_q,
  input logic [7:0]        run_sec
);
  logic rd, inwin;
  assign rd    = req_valid && !req_write;
  assign inwin = &req_addr[ADDR_W-1:3];

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid); // R12
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid); // R12
  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !inwin) |=> (rsp_data == 8'h00)); // R2
  AST_MONTH_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && inwin && req_addr[2:0] == 3'd6) |=> (rsp_data[7:5] == 3'd0)); // R3
  AST_BATT_FLAG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && inwin && req_addr[2:0] == 3'd4) |=> (rsp_data[7] == $past(batt_ok))); // R11
  AST_STOP_HOLDS_SECONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_q && !w_q) |=> $stable(run_sec)); // R10
endmodule

bind rtc_calendar_window rtc_window_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .batt_ok(batt_ok), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .osc_q(osc_q), .w_q(w_q), .run_sec(cnt_q[0])
);

// File: tb/sim_rtc_calendar_window.sv
`timescale 1ns/1ps
module sim_rtc_calendar_window;
  localparam int AW = 13;
  localparam logic [AW-1:0] BASE = 13'h1FF8;

  logic clk = 0, rst_n = 0, tick_1hz = 0, batt_ok = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  rtc_calendar_window #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .batt_ok(batt_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  // ---------------- behavioural model (index = window offset) ----------
  int mi[8], mu[8];
  bit mw, mr, mosc, mft;
  bit exp_v;
  logic [7:0] exp_d;
  string exp_tag;

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic logic [7:0] mask_of(int o);
    case (o)
      0, 3, 5: return 8'h3F;
      1, 2:    return 8'h7F;
      4:       return 8'h07;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] view(int o);
    case (o)
      0: return {mw, mr, i2b(mu[0])[5:0]};
      1: return {mosc, i2b(mu[1])[6:0]};
      4: return {batt_ok, mft, 3'd0, 3'(mu[4])};
      default: return i2b(mu[o]);
    endcase
  endfunction

  task automatic advance();
    mi[1]++;
    if (mi[1] < 60) return;
    mi[1] = 0; mi[2]++;
    if (mi[2] < 60) return;
    mi[2] = 0; mi[3]++;
    if (mi[3] < 24) return;
    mi[3] = 0; mi[4] = (mi[4] % 7) + 1; mi[5]++;
    if (mi[5] <= mdays(mi[6], mi[7])) return;
    mi[5] = 1; mi[6]++;
    if (mi[6] <= 12) return;
    mi[6] = 1; mi[7]++;
    if (mi[7] <= 99) return;
    mi[7] = 0; mi[0]++;
    if (mi[0] > 39) mi[0] = 0;
  endtask

  task automatic model_reset();
    mi = '{20, 0, 0, 0, 1, 1, 1, 0};
    mu = mi;
    mw = 0; mr = 0; mosc = 0; mft = 0;
    exp_v = 0; exp_d = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int pre[8];
      bit inwin, ld, refresh;
      int o;
      pre = mi;
      inwin = (req_addr[AW-1:3] == '1);
      o = int'(req_addr[2:0]);
      exp_v = req_valid && !req_write;
      if (exp_v) begin
        exp_d = inwin ? view(o) : 8'h00;
        exp_tag = cur_tag;
      end
      ld = req_valid && req_write && inwin && o == 0 && !req_wdata[7] && mw;
      if (ld) begin
        mi = mu;
        mi[0] = b2i(req_wdata & 8'h3F);
      end else if (tick_1hz && !mosc) advance();
      refresh = !mw && !mr;
      for (int k = 0; k < 8; k++) begin
        if (req_valid && req_write && inwin && o == k) begin
          if (k == 4) mu[k] = int'(req_wdata[2:0]);
          else        mu[k] = b2i(req_wdata & mask_of(k));
        end else if (refresh) mu[k] = pre[k];
      end
      if (req_valid && req_write && inwin) begin
        if (o == 0) begin mw = req_wdata[7]; mr = req_wdata[6]; end
        if (o == 1) mosc = req_wdata[7];
        if (o == 4) mft = req_wdata[6];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid !== exp_v) begin
        checks++; errors++;
        $display("FAIL R12: rsp_valid actual %b expected %b", rsp_valid, exp_v);
      end else if (exp_v) begin
        checks++;
        if (rsp_data !== exp_d) begin
          errors++;
          $display("FAIL %s: rsp_data actual %h expected %h", exp_tag, rsp_data, exp_d);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic wr(logic [AW-1:0] a, logic [7:0] d, bit with_tick = 0);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; tick_1hz = with_tick;
    @(negedge clk);
    req_valid = 0; req_write = 0; tick_1hz = 0;
  endtask
  task automatic rd(logic [AW-1:0] a, string tag);
    cur_tag = tag;
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz = 1; @(negedge clk); tick_1hz = 0; @(negedge clk);
    end
  endtask
  task automatic set_time(logic [7:0] c, y, mo, dt, dw, h, mn, s);
    wr(BASE + 0, {2'b10, c[5:0]});
    wr(BASE + 7, y); wr(BASE + 6, mo); wr(BASE + 5, dt); wr(BASE + 4, dw);
    wr(BASE + 3, h); wr(BASE + 2, mn); wr(BASE + 1, s);
    wr(BASE + 0, {2'b00, c[5:0]});
    idle(2);
  endtask
  task automatic rd_all(string tag);
    for (int k = 0; k < 8; k++) rd(BASE + 13'(k), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    rd_all("R1");                                  // reset state
    if (req_ready !== 1'b1) begin
      errors++; $display("FAIL R12: req_ready actual %b expected 1", req_ready);
    end
    checks++;
    // R2: outside window, aliasing onto year must not happen
    wr(BASE + 0, 8'hA0);
    wr(13'h1FF7, 8'h55);
    wr(13'h0007, 8'h66);
    rd(BASE + 7, "R2");
    rd(13'h0FFF, "R2");
    // R3: unused bits dropped
    wr(BASE + 6, 8'hF2); wr(BASE + 3, 8'hE3); wr(BASE + 2, 8'hD9);
    rd(BASE + 6, "R3"); rd(BASE + 3, "R3"); rd(BASE + 2, "R3");
    wr(BASE + 0, 8'h20); idle(2);
    // R4 / R6: seconds through midnight, year rollover into next year
    set_time(8'h20, 8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    ticks(1); rd(BASE + 1, "R4");
    ticks(1); rd_all("R4"); rd(BASE + 4, "R6");
    // R5: leap February, plain February, 30-day month
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1); rd(BASE + 5, "R5"); rd(BASE + 6, "R5");
    ticks(86400 / 86400); rd(BASE + 5, "R5");
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1); rd(BASE + 5, "R5"); rd(BASE + 6, "R5");
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1); rd(BASE + 5, "R5"); rd(BASE + 6, "R5");
    set_time(8'h20, 8'h21, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
    ticks(1); rd(BASE + 5, "R5"); rd(BASE + 6, "R5"); rd(BASE + 4, "R6");
    // R7: century rollover
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(1); rd(BASE + 0, "R7"); rd(BASE + 7, "R7");
    set_time(8'h21, 8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(1); rd(BASE + 0, "R7");
    // R8: freeze while counting continues
    set_time(8'h20, 8'h10, 8'h05, 8'h05, 8'h01, 8'h10, 8'h10, 8'h10);
    wr(BASE + 0, 8'h60);
    ticks(3); rd(BASE + 1, "R8"); rd(BASE + 0, "R8");
    wr(BASE + 0, 8'h20); idle(1);
    rd(BASE + 1, "R8");
    // R10: stop bit, same-cycle field write vs refresh
    wr(BASE + 1, 8'h80);
    idle(1); rd(BASE + 1, "R10");
    ticks(3); rd(BASE + 1, "R10");
    wr(BASE + 1, 8'h00); idle(1);
    ticks(1); rd(BASE + 1, "R10");
    // R9: load bit suspends refresh; release collides with a tick
    wr(BASE + 0, 8'hA0);
    wr(BASE + 1, 8'h10);
    ticks(2); rd(BASE + 1, "R9"); rd(BASE + 2, "R9");
    wr(BASE + 0, 8'h20, 1);
    idle(1); rd(BASE + 1, "R9");
    ticks(1); rd(BASE + 1, "R9");
    // R11: battery flag live, not writable; test bit writable
    batt_ok = 0; rd(BASE + 4, "R11");
    wr(BASE + 4, 8'hC3); idle(1); rd(BASE + 4, "R11");
    batt_ok = 1; rd(BASE + 4, "R11");
    wr(BASE + 4, 8'h03); idle(1); rd(BASE + 4, "R11");
    // R12: back-to-back reads, writes with no response
    cur_tag = "R12";
    req_valid = 1; req_write = 0; req_addr = BASE + 7;
    @(negedge clk); req_addr = BASE + 6;
    @(negedge clk); req_valid = 0;
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule